// File: doc/BRIEF.md
# Backplane Hit Serializer and Concentrator Receiver

This block carries detector hits from front-end boards across a narrow synchronous backplane and rebuilds them on a concentrator. Each board owns a lane made of five data lines and one valid line. A 15-bit hit (7-bit channel number, 8-bit fine time) crosses its lane as three 5-bit words. The lane moves one word per backplane strobe, a clock-enable at one tenth of the 250 MHz processing clock.

On the concentrator side, each lane has a deframer that rebuilds complete three-word groups. It extends each hit with a 10-bit coarse time taken from a local counter, corrected by one step when the fine time shows that the counter wrapped while the hit was in transit. The resulting record goes into that lane's buffer. A round-robin arbiter merges all lane buffers into one 29-bit record stream, at most one record per clock, and stops when the downstream FIFO reports full. Lanes never wait on one another. A lane whose buffer fills drops its further hits and raises a sticky flag.

Both sides sit in one module. The backplane wiring between them is external (`bp_*_o` to `bp_*_i`), so the receiver can also be fed any lane pattern.

Top module: `bp_hit_link`

## Requirements
- R1: A hit is taken on a clock edge where both `hit_valid[i]` and `hit_ready[i]` are high. `hit_ready[i]` stays low until the hit has been sent. The lane changes only on edges where `bp_ce` is high. It sends three words on consecutive strobes with valid high, in this order: word 0 = chan[6:2], word 1 = {chan[1:0], fine[7:5]}, word 2 = fine[4:0]. It then holds valid low for at least one strobe.
- R2: The receiver samples a lane only on `bp_ce` edges. A group starts at a valid word that follows a strobe where valid was low. Three consecutive valid strobes form one hit.
- R3: A group whose valid drops before the third word yields no record. After a complete group, further valid strobes are ignored until valid has been low for one strobe.
- R4: The fine counter counts clocks since reset, modulo 256. The coarse counter steps once each time the fine counter wraps. The strobe edge that samples the third word sets the coarse tag: it is the coarse count minus one (modulo 1024) when the received fine time is greater than the current fine count, and the coarse count otherwise.
- R5: Output record layout: `out_data[28:25]` = lane index, `[24:15]` = coarse tag, `[14:8]` = channel, `[7:0]` = fine time.
- R6: Every complete group on a lane that is not full appears on the output exactly once. Records from the same lane keep their order.
- R7: Lanes are independent. Groups completing on all lanes on the same strobe are all delivered.
- R8: When several lanes hold records and there is no backpressure, one record leaves per clock. The lane picked is the first non-empty lane after the last one served, in ascending cyclic order. After reset, lane 0 comes first.
- R9: If `out_full` is high at an edge, no record is issued on that edge (`out_valid` is low after it). Held records are kept.
- R10: A lane buffer holds `LANE_DEPTH` records. A group that completes while that buffer is full is dropped and sets `lane_ovf[i]`, which stays set until reset. Other lanes are unaffected.
- R11: During reset, `out_valid`, `bp_vld_o` and `lane_ovf` are all zero and `hit_ready` is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 250 MHz processing clock |
| rst | input | 1 | Synchronous active-high reset |
| bp_ce | input | 1 | Backplane word strobe (one clock in ten) |
| hit_valid | input | 13 | Per-board hit offered |
| hit_chan | input | 91 | Per-board 7-bit channel, board i at [7i+6:7i] |
| hit_fine | input | 104 | Per-board 8-bit fine time, board i at [8i+7:8i] |
| hit_ready | output | 13 | Per-board serializer idle |
| bp_vld_o | output | 13 | Lane valid lines driven by the boards |
| bp_word_o | output | 65 | Lane data lines driven by the boards, 5 per lane |
| bp_vld_i | input | 13 | Lane valid lines seen by the concentrator |
| bp_word_i | input | 65 | Lane data lines seen by the concentrator |
| out_full | input | 1 | Downstream FIFO full |
| out_valid | output | 1 | Merged record valid |
| out_data | output | 29 | Merged record |
| lane_ovf | output | 13 | Sticky per-lane buffer overflow |

## Verification
The bench checks the coarse-tag correction in both directions, including a hit at coarse zero with fine time 255. A design that compares fine times the wrong way, or that does not wrap the subtraction, shows up as a coarse tag that is 1 or 1023 steps away from the expected value. It injects short and long valid runs on a lane. A deframer that keeps partial groups or restarts in the middle of a run would emit extra or garbled records. It fills three lanes while the output is held full and then releases it. This checks the rotation order and one record per clock, which a fixed-priority or stalling arbiter would break. It also overfills one lane, to confirm that exactly `LANE_DEPTH` records survive, that the flag stays set, and that the neighbouring lanes keep working.

// File: rtl/bphl_pkg.sv
package bphl_pkg;

  typedef enum logic [1:0] {
    TX_IDLE   = 2'd0,
    TX_LOADED = 2'd1,
    TX_SEND   = 2'd2
  } tx_state_e;

  function automatic int div_up(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

endpackage

// File: rtl/bphl_tx.sv
module bphl_tx
  import bphl_pkg::*;
#(
  parameter int CHAN_W = 7,
  parameter int FINE_W = 8,
  parameter int WORD_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce,
  input  logic              hit_valid,
  input  logic [CHAN_W-1:0] hit_chan,
  input  logic [FINE_W-1:0] hit_fine,
  output logic              hit_ready,
  output logic              lane_vld,
  output logic [WORD_W-1:0] lane_word
);
  localparam int HIT_W  = CHAN_W + FINE_W;
  localparam int NWORDS = div_up(HIT_W, WORD_W);
  localparam int PAD_W  = NWORDS * WORD_W;
  localparam int CNT_W  = $clog2(NWORDS + 1);

  tx_state_e          st;
  logic [PAD_W-1:0]   sh;
  logic [CNT_W-1:0]   sent;

  assign hit_ready = (st == TX_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= TX_IDLE;
      sh        <= '0;
      sent      <= '0;
      lane_vld  <= 1'b0;
      lane_word <= '0;
    end else begin
      case (st)
        TX_IDLE: begin
          if (hit_valid) begin
            sh <= PAD_W'({hit_chan, hit_fine}) << (PAD_W - HIT_W);
            st <= TX_LOADED;
          end
        end
        TX_LOADED: begin
          if (ce) begin
            lane_word <= sh[PAD_W-1 -: WORD_W];
            sh        <= sh << WORD_W;
            lane_vld  <= 1'b1;
            sent      <= CNT_W'(1);
            st        <= TX_SEND;
          end
        end
        TX_SEND: begin
          if (ce) begin
            if (sent == CNT_W'(NWORDS)) begin
              lane_vld  <= 1'b0;
              lane_word <= '0;
              st        <= TX_IDLE;
            end else begin
              lane_word <= sh[PAD_W-1 -: WORD_W];
              sh        <= sh << WORD_W;
              sent      <= sent + CNT_W'(1);
            end
          end
        end
        default: st <= TX_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/bphl_rx.sv
module bphl_rx
  import bphl_pkg::*;
#(
  parameter int CHAN_W   = 7,
  parameter int FINE_W   = 8,
  parameter int WORD_W   = 5,
  parameter int COARSE_W = 10
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              ce,
  input  logic                              lane_vld,
  input  logic [WORD_W-1:0]                 lane_word,
  input  logic [FINE_W-1:0]                 fine_now,
  input  logic [COARSE_W-1:0]               coarse_now,
  output logic                              rec_valid,
  output logic [COARSE_W+CHAN_W+FINE_W-1:0] rec_data
);
  localparam int HIT_W  = CHAN_W + FINE_W;
  localparam int NWORDS = div_up(HIT_W, WORD_W);
  localparam int PAD_W  = NWORDS * WORD_W;
  localparam int CNT_W  = $clog2(NWORDS + 1);

  logic               prev_vld;
  logic [CNT_W-1:0]   got;
  logic [PAD_W-1:0]   sh;
  logic [PAD_W-1:0]   sh_next;
  logic [HIT_W-1:0]   hit_next;
  logic               late;
  logic [COARSE_W-1:0] coarse_tag;

  assign sh_next    = (sh << WORD_W) | PAD_W'(lane_word);
  assign hit_next   = sh_next[PAD_W-1 -: HIT_W];
  assign late       = hit_next[FINE_W-1:0] > fine_now;
  assign coarse_tag = coarse_now - COARSE_W'(late);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_vld  <= 1'b0;
      got       <= '0;
      sh        <= '0;
      rec_valid <= 1'b0;
      rec_data  <= '0;
    end else begin
      rec_valid <= 1'b0;
      if (ce) begin
        prev_vld <= lane_vld;
        if (!lane_vld) begin
          got <= '0;
        end else if (!prev_vld) begin
          sh  <= PAD_W'(lane_word);
          got <= CNT_W'(1);
        end else if (got != '0 && got < CNT_W'(NWORDS)) begin
          sh  <= sh_next;
          got <= got + CNT_W'(1);
          if (got == CNT_W'(NWORDS - 1)) begin
            rec_valid <= 1'b1;
            rec_data  <= {coarse_tag, hit_next};
          end
        end
      end
    end
  end

endmodule

// File: rtl/bphl_lane_fifo.sv
module bphl_lane_fifo #(
  parameter int W     = 25,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         empty,
  output logic         ovf
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          full, push, pop;

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign push    = wr_en && !full;
  assign pop     = rd_en && !empty;
  assign rd_data = mem[rp];

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
      ovf <= 1'b0;
    end else begin
      if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
      if (pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
      case ({push, pop})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
      if (wr_en && full) ovf <= 1'b1;
    end
  end

endmodule

// File: rtl/bphl_rr_arb.sv
module bphl_rr_arb #(
  parameter int N = 13
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N-1:0]         req,
  input  logic                 en,
  output logic                 gnt_valid,
  output logic [$clog2(N)-1:0] gnt_idx
);
  localparam int IW = $clog2(N);

  logic [IW-1:0] last;

  always_comb begin
    gnt_valid = 1'b0;
    gnt_idx   = '0;
    for (int off = 1; off <= N; off++) begin : g_scan
      int cand;
      cand = int'(last) + off;
      if (cand >= N) cand = cand - N;
      if (!gnt_valid && en && req[IW'(cand)]) begin
        gnt_valid = 1'b1;
        gnt_idx   = IW'(cand);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            last <= IW'(N - 1);
    else if (gnt_valid) last <= gnt_idx;
  end

endmodule

// File: rtl/bp_hit_link.sv
module bp_hit_link
  import bphl_pkg::*;
#(
  parameter int N_LANES    = 13,
  parameter int WORD_W     = 5,
  parameter int CHAN_W     = 7,
  parameter int FINE_W     = 8,
  parameter int COARSE_W   = 10,
  parameter int TAG_W      = 4,
  parameter int LANE_DEPTH = 16
) (
  input  logic                                    clk,
  input  logic                                    rst,
  input  logic                                    bp_ce,
  input  logic [N_LANES-1:0]                      hit_valid,
  input  logic [N_LANES*CHAN_W-1:0]               hit_chan,
  input  logic [N_LANES*FINE_W-1:0]               hit_fine,
  output logic [N_LANES-1:0]                      hit_ready,
  output logic [N_LANES-1:0]                      bp_vld_o,
  output logic [N_LANES*WORD_W-1:0]               bp_word_o,
  input  logic [N_LANES-1:0]                      bp_vld_i,
  input  logic [N_LANES*WORD_W-1:0]               bp_word_i,
  input  logic                                    out_full,
  output logic                                    out_valid,
  output logic [TAG_W+COARSE_W+CHAN_W+FINE_W-1:0] out_data,
  output logic [N_LANES-1:0]                      lane_ovf
);
  localparam int REC_W = COARSE_W + CHAN_W + FINE_W;
  localparam int IW    = $clog2(N_LANES);

  logic [FINE_W-1:0]   fine_cnt;
  logic [COARSE_W-1:0] coarse_cnt;
  logic [N_LANES-1:0]  rec_valid;
  logic [REC_W-1:0]    rec_data [N_LANES];
  logic [REC_W-1:0]    fifo_q   [N_LANES];
  logic [N_LANES-1:0]  fifo_empty;
  logic [N_LANES-1:0]  rd_en;
  logic                gnt_valid;
  logic [IW-1:0]       gnt_idx;

  // Local timebase: fine counter in clocks, coarse steps on each fine wrap.
  always_ff @(posedge clk) begin
    if (rst) begin
      fine_cnt   <= '0;
      coarse_cnt <= '0;
    end else begin
      fine_cnt <= fine_cnt + FINE_W'(1);
      if (&fine_cnt) coarse_cnt <= coarse_cnt + COARSE_W'(1);
    end
  end

  for (genvar i = 0; i < N_LANES; i++) begin : g_lane
    bphl_tx #(
      .CHAN_W(CHAN_W), .FINE_W(FINE_W), .WORD_W(WORD_W)
    ) u_tx (
      .clk       (clk),
      .rst       (rst),
      .ce        (bp_ce),
      .hit_valid (hit_valid[i]),
      .hit_chan  (hit_chan[i*CHAN_W +: CHAN_W]),
      .hit_fine  (hit_fine[i*FINE_W +: FINE_W]),
      .hit_ready (hit_ready[i]),
      .lane_vld  (bp_vld_o[i]),
      .lane_word (bp_word_o[i*WORD_W +: WORD_W])
    );

    bphl_rx #(
      .CHAN_W(CHAN_W), .FINE_W(FINE_W), .WORD_W(WORD_W), .COARSE_W(COARSE_W)
    ) u_rx (
      .clk        (clk),
      .rst        (rst),
      .ce         (bp_ce),
      .lane_vld   (bp_vld_i[i]),
      .lane_word  (bp_word_i[i*WORD_W +: WORD_W]),
      .fine_now   (fine_cnt),
      .coarse_now (coarse_cnt),
      .rec_valid  (rec_valid[i]),
      .rec_data   (rec_data[i])
    );

    bphl_lane_fifo #(
      .W(REC_W), .DEPTH(LANE_DEPTH)
    ) u_fifo (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (rec_valid[i]),
      .wr_data (rec_data[i]),
      .rd_en   (rd_en[i]),
      .rd_data (fifo_q[i]),
      .empty   (fifo_empty[i]),
      .ovf     (lane_ovf[i])
    );

    assign rd_en[i] = gnt_valid && (gnt_idx == IW'(i));
  end

  bphl_rr_arb #(.N(N_LANES)) u_arb (
    .clk       (clk),
    .rst       (rst),
    .req       (~fifo_empty),
    .en        (!out_full),
    .gnt_valid (gnt_valid),
    .gnt_idx   (gnt_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= gnt_valid;
      if (gnt_valid) out_data <= {TAG_W'(gnt_idx), fifo_q[gnt_idx]};
    end
  end

endmodule

// File: rtl/bp_hit_link_chk.sv
module bp_hit_link_chk #(
  parameter int N_LANES = 13,
  parameter int WORD_W  = 5,
  parameter int TAG_W   = 4,
  parameter int NWORDS  = 3
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      bp_ce,
  input logic [N_LANES-1:0]        bp_vld_o,
  input logic [N_LANES*WORD_W-1:0] bp_word_o,
  input logic                      out_full,
  input logic                      out_valid,
  input logic [TAG_W-1:0]          out_tag,
  input logic [N_LANES-1:0]        lane_ovf
);

  // R1: lane lines move only after a strobe edge
  a_r1_lane_on_strobe: assert property (@(posedge clk) disable iff (rst)
    !bp_ce |=> ($stable(bp_vld_o) && $stable(bp_word_o)));

  // R1: never more than NWORDS valid strobes in a row per lane
  for (genvar i = 0; i < N_LANES; i++) begin : g_run
    logic [7:0] run;
    always_ff @(posedge clk) begin
      if (rst) run <= '0;
      else if (bp_ce) run <= bp_vld_o[i] ? ((run == 8'hFF) ? run : run + 8'd1) : 8'd0;
    end
    always @(posedge clk) begin
      if (!rst) a_r1_word_run: assert (run <= 8'(NWORDS));
    end
  end

  // R9: no record issued on an edge that saw full
  a_r9_hold_when_full: assert property (@(posedge clk) disable iff (rst)
    out_full |=> !out_valid);

  // R10: overflow flags never clear
  a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((lane_ovf & $past(lane_ovf)) == $past(lane_ovf)));

  // R5: lane tag names an existing lane
  a_r5_tag_in_range: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (int'(out_tag) < N_LANES));

  // R11: quiet right after reset release
  a_r11_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!out_valid && lane_ovf == '0 && bp_vld_o == '0));

endmodule

bind bp_hit_link bp_hit_link_chk #(
  .N_LANES (N_LANES),
  .WORD_W  (WORD_W),
  .TAG_W   (TAG_W),
  .NWORDS  ((CHAN_W + FINE_W + WORD_W - 1) / WORD_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bp_ce     (bp_ce),
  .bp_vld_o  (bp_vld_o),
  .bp_word_o (bp_word_o),
  .out_full  (out_full),
  .out_valid (out_valid),
  .out_tag   (out_data[TAG_W+COARSE_W+CHAN_W+FINE_W-1 -: TAG_W]),
  .lane_ovf  (lane_ovf)
);

// File: tb/sim_bp_hit_link.sv
`timescale 1ns/1ps
module sim_bp_hit_link;
  localparam int N = 13;
  localparam int DEPTH = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bp_ce = 1'b0;
  logic [N-1:0]  hit_valid = '0;
  logic [N*7-1:0] hit_chan = '0;
  logic [N*8-1:0] hit_fine = '0;
  logic [N-1:0]  hit_ready, bp_vld_o, bp_vld_i, lane_ovf;
  logic [N*5-1:0] bp_word_o, bp_word_i;
  logic          out_full = 1'b0;
  logic          out_valid;
  logic [28:0]   out_data;
  logic [N-1:0]  inj_en = '0, inj_vld = '0;
  logic [N*5-1:0] inj_word = '0;

  int n_checks = 0, n_errors = 0, n_out = 0, cyc = 0, div = 0;
  bit done = 0;

  always #10 clk = ~clk;

  bp_hit_link #(.N_LANES(N), .WORD_W(5), .CHAN_W(7), .FINE_W(8), .COARSE_W(10),
                .TAG_W(4), .LANE_DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst), .bp_ce(bp_ce), .hit_valid(hit_valid), .hit_chan(hit_chan),
    .hit_fine(hit_fine), .hit_ready(hit_ready), .bp_vld_o(bp_vld_o), .bp_word_o(bp_word_o),
    .bp_vld_i(bp_vld_i), .bp_word_i(bp_word_i), .out_full(out_full), .out_valid(out_valid),
    .out_data(out_data), .lane_ovf(lane_ovf));

  // backplane wiring with per-lane override
  always_comb begin
    bp_vld_i = (bp_vld_o & ~inj_en) | (inj_vld & inj_en);
    for (int i = 0; i < N; i++)
      bp_word_i[i*5 +: 5] = inj_en[i] ? inj_word[i*5 +: 5] : bp_word_o[i*5 +: 5];
  end

  always @(posedge clk) begin
    if (rst) cyc <= 0; else cyc <= cyc + 1;
  end

  always @(posedge clk) begin
    #1;
    div = (div + 1) % 10;
    bp_ce = (div == 0);
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  logic [28:0] q [N][$];
  int m_prev[N], m_got[N], m_sh[N], m_occ[N], m_run[N];
  logic [N-1:0] m_ovf;
  bit full_prev;
  int tag_log[$];
  int cyc_log[$];
  logic [28:0] last_out;

  always @(negedge clk) begin
    if (rst) begin
      for (int l = 0; l < N; l++) begin
        m_prev[l] = 0; m_got[l] = 0; m_sh[l] = 0; m_occ[l] = 0; m_run[l] = 0;
        q[l].delete();
      end
      m_ovf = '0;
      full_prev = 0;
    end else begin
      if (out_valid) begin
        int tg;
        tg = int'(out_data[28:25]);
        n_out++;
        last_out = out_data;
        tag_log.push_back(tg);
        cyc_log.push_back(cyc);
        check(!full_prev, "R9 record issued while full", 1, 0);
        if (tg >= N || q[tg].size() == 0) begin
          check(0, "R6 unexpected record", out_data, 0);
        end else begin
          check(out_data == q[tg][0], "R5/R6 record content", out_data, q[tg][0]);
          void'(q[tg].pop_front());
          m_occ[tg]--;
        end
      end
      full_prev = out_full;
      if (bp_ce) begin
        for (int l = 0; l < N; l++) begin
          bit v;
          int w;
          // transmit-side word run length
          if (bp_vld_o[l]) m_run[l]++;
          else if (m_run[l] > 0) begin
            check(m_run[l] == 3, "R1 words per hit", m_run[l], 3);
            m_run[l] = 0;
          end
          // receive-side framing
          v = bp_vld_i[l];
          w = int'(bp_word_i[l*5 +: 5]);
          if (!v) m_got[l] = 0;
          else if (m_prev[l] == 0) begin m_sh[l] = w; m_got[l] = 1; end
          else if (m_got[l] == 1) begin m_sh[l] = (m_sh[l] << 5) | w; m_got[l] = 2; end
          else if (m_got[l] == 2) begin
            int hit, fnow, cnow, ctag;
            hit  = ((m_sh[l] << 5) | w) & 32'h7FFF;
            fnow = cyc % 256;
            cnow = (cyc / 256) % 1024;
            ctag = ((hit & 255) > fnow) ? (cnow + 1023) % 1024 : cnow;
            if (m_occ[l] < DEPTH) begin
              q[l].push_back({4'(l), 10'(ctag), 15'(hit)});
              m_occ[l]++;
            end else m_ovf[l] = 1'b1;
            m_got[l] = 3;
          end
          m_prev[l] = int'(v);
        end
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic send_hits(input logic [N-1:0] mask, input logic [6:0] chan, input logic [7:0] fine);
    do step(1); while ((hit_ready & mask) != mask);
    for (int l = 0; l < N; l++) begin
      hit_chan[l*7 +: 7] = chan ^ 7'(l);
      hit_fine[l*8 +: 8] = fine + 8'(l * 17);
    end
    hit_valid = mask;
    step(1);
    hit_valid = '0;
    check((hit_ready & mask) == '0, "R1 busy after accept", hit_ready & mask, 0);
  endtask

  task automatic wait_ce();
    do step(1); while (!bp_ce);
  endtask

  // drive nw valid words on lane l, then one idle strobe
  task automatic inject(input int l, input int nw, input logic [4:0] w0);
    inj_en[l] = 1'b1;
    inj_vld[l] = 1'b0;
    wait_ce();
    for (int k = 0; k < nw; k++) begin
      inj_vld[l] = 1'b1;
      inj_word[l*5 +: 5] = w0 + 5'(k * 7);
      wait_ce();
    end
    inj_vld[l] = 1'b0;
    wait_ce();
    inj_en[l] = 1'b0;
  endtask

  // ---------------- main sequence ----------------
  initial begin
    int base, exp_lane, first;
    int pend[N];
    step(4);
    // R11 reset state
    check(out_valid == 1'b0, "R11 out_valid in reset", out_valid, 0);
    check(hit_ready == '1, "R11 hit_ready in reset", hit_ready, 13'h1FFF);
    check(bp_vld_o == '0, "R11 lane valid in reset", bp_vld_o, 0);
    check(lane_ovf == '0, "R11 overflow in reset", lane_ovf, 0);
    rst = 1'b0;

    // R4: fine 255 during coarse 0 wraps the tag to 1023
    send_hits(13'h1, 7'h2A, 8'hFF);
    step(80);
    check(last_out[24:15] == 10'h3FF, "R4 coarse wrap below zero", last_out[24:15], 10'h3FF);
    check(last_out[14:0] == {7'h2A, 8'hFF}, "R2 hit fields", last_out[14:0], {7'h2A, 8'hFF});

    // R1 R2 R5: assorted bit patterns on several lanes
    send_hits(13'h2, 7'h7F, 8'h00);
    send_hits(13'h10, 7'h00, 8'hFF);
    send_hits(13'h400, 7'h55, 8'hAA);
    send_hits(13'h1000, 7'h2A, 8'h33);
    step(300);
    send_hits(13'h8, 7'h11, 8'h01);
    step(80);
    check(last_out[28:25] == 4'd3, "R5 lane tag", last_out[28:25], 3);

    // R7: all lanes at once
    base = n_out;
    send_hits('1, 7'h0C, 8'h80);
    step(80);
    check(n_out - base == N, "R7 all lanes delivered", n_out - base, N);

    // R3: partial group dropped, long run gives one record
    base = n_out;
    inject(3, 2, 5'h1A);
    step(20);
    check(n_out == base, "R3 partial group dropped", n_out - base, 0);
    inject(3, 5, 5'h05);
    step(20);
    check(n_out - base == 1, "R3 long run one record", n_out - base, 1);
    inject(6, 3, 5'h13);
    step(20);
    check(n_out - base == 2, "R2 injected group", n_out - base, 2);

    // R8 R9: hold output, fill lanes 1,4,9, release
    out_full = 1'b1;
    base = n_out;
    send_hits(13'h212, 7'h21, 8'h44);
    send_hits(13'h212, 7'h62, 8'h05);
    step(80);
    check(n_out == base, "R9 nothing while full", n_out - base, 0);
    for (int l = 0; l < N; l++) pend[l] = (l == 1 || l == 4 || l == 9) ? 2 : 0;
    exp_lane = int'(last_out[28:25]);
    tag_log.delete();
    cyc_log.delete();
    out_full = 1'b0;
    step(30);
    check(tag_log.size() == 6, "R9 held records released", tag_log.size(), 6);
    for (int k = 0; k < 6 && k < tag_log.size(); k++) begin
      do exp_lane = (exp_lane + 1) % N; while (pend[exp_lane] == 0);
      pend[exp_lane]--;
      check(tag_log[k] == exp_lane, "R8 rotation order", tag_log[k], exp_lane);
    end
    if (cyc_log.size() == 6) begin
      first = cyc_log[0];
      check(cyc_log[5] - first == 5, "R8 one record per clock", cyc_log[5] - first, 5);
    end

    // R10: overfill lane 2
    out_full = 1'b1;
    for (int k = 0; k < DEPTH + 3; k++) send_hits(13'h4, 7'(k), 8'(k * 9));
    step(80);
    check(lane_ovf == 13'h4, "R10 overflow flag", lane_ovf, 13'h4);
    check(m_ovf == 13'h4, "R10 model agrees on drop", m_ovf, 13'h4);
    tag_log.delete();
    out_full = 1'b0;
    step(40);
    check(tag_log.size() == DEPTH, "R10 buffer depth kept", tag_log.size(), DEPTH);
    base = n_out;
    send_hits(13'h24, 7'h3C, 8'h10);
    step(80);
    check(n_out - base == 2, "R10 lanes still working", n_out - base, 2);
    check(lane_ovf == 13'h4, "R10 flag sticky", lane_ovf, 13'h4);

    // R6: nothing left behind
    for (int l = 0; l < N; l++)
      check(q[l].size() == 0, "R6 all records delivered", q[l].size(), 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

  initial begin
    #3000000;
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL R6 watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  end

endmodule